// File: doc/BRIEF.md
# Flash Sector Protection Arbiter

This block sits between a flash command decoder and the program/erase engine. The array has uniform sectors, and consecutive runs of sectors share one stored protect bit per group. Each request names an operation and a sector. The block answers whether the operation may touch the array. It also reports, for a whole-array erase, which sectors may be erased, and it reads back or changes the stored group protect bits.

A sector is protected when one of two things holds. The first is that its group bit is set while neither the temporary-unlock flag nor the acceleration flag is active. The second is that it is the boundary sector while the hardware lock input is low. The boundary sector is the lowest or the highest sector, and a build-time parameter picks which. The high-voltage sensing behind these flags lives outside the block, and the flags arrive as plain digital levels.

Requests use a valid/ready handshake. The response sits in a single output register and also uses valid/ready. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high, and `req_ready` equals `!rsp_valid || rsp_ready`. While a response waits with `rsp_ready` low, that response holds still and no new request is taken. The mode inputs are sampled on the accepting edge. Each response reflects the stored bits as they were before that request changed them.

Top module: `flash_sector_guard`

## Requirements
- R1: After reset, every group protect bit equals the parameter RESET_PROT (default 0), `rsp_valid` and `deny_pulse` are low, and `req_ready` is high.
- R2: For operation code 0 (program) or 1 (sector erase), `rsp_grant` is 1 when the target sector is unprotected and 0 when it is protected. Codes 6 and 7 are always refused.
- R3: A sector belongs to group `sector / GROUP_SIZE` (bits 6:2 of the sector number by default). Protecting one group affects only that group's sectors.
- R4: While `lock_n` is low, requests to the boundary sector (sector 0 when LOCK_TOP=0, the last sector otherwise) are refused whatever the group bits and flags say. Other sectors in the same group are unaffected.
- R5: While `lock_n` is high, the boundary sector follows its group bit.
- R6: While `tmp_unlock` is high, sectors in protected groups are granted, but the boundary lock still applies. Once the flag drops, the stored protection is in force again unchanged.
- R7: While `accel_mode` is high, every group counts as unprotected, and the boundary lock still applies.
- R8: Operation code 4 (unprotect group) is granted only when every group bit is set, and then it clears only the addressed group's bit. Otherwise it is refused and no bit changes.
- R9: Operation code 5 (verify) is always granted. It returns `rsp_status` 8'h01 when the addressed group's stored bit is set and 8'h00 when it is clear, regardless of the temporary-unlock and acceleration flags. All other operations return 8'h00.
- R10: Operation code 2 (whole-array erase) returns `rsp_erase_mask` with bit i set exactly when sector i is unprotected, and it is granted only if the mask is nonzero. Every other operation returns an all-zero mask.
- R11: `deny_pulse` is high for exactly the cycle after each accepted request that is refused, and it is low otherwise.
- R12: A response held with `rsp_ready` low keeps all its fields stable, and no new request is accepted until it is taken.
- R13: Operation code 3 (protect group) is always granted and sets the addressed group's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_n | input | 1 | Hardware lock; low locks the boundary sector |
| tmp_unlock | input | 1 | Temporary unlock of all protected groups |
| accel_mode | input | 1 | Acceleration mode; groups count as unprotected |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code |
| req_sector | input | 7 | Target sector number |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_grant | output | 1 | 1 when the operation is permitted |
| rsp_status | output | 8 | Verify result (01h protected, 00h open) |
| rsp_erase_mask | output | 128 | Erasable sectors for a whole-array erase |
| deny_pulse | output | 1 | One-cycle strobe for each refused request |

## Verification
The properties assume that the flag levels present on the accepting edge govern that request, and that a request stays unchanged while `req_valid` is high and `req_ready` is low. The stimulus changes inputs only on falling clock edges, so each level is settled before the edge that samples it. During the back-pressure scenario the pending request is held steady until the response is taken. Operation codes outside the defined set are sent on purpose, and the refusal properties cover them as well.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    OP_PROGRAM    = 3'd0,
    OP_SECT_ERASE = 3'd1,
    OP_CHIP_ERASE = 3'd2,
    OP_PROTECT    = 3'd3,
    OP_UNPROTECT  = 3'd4,
    OP_VERIFY     = 3'd5
  } op_e;

  localparam logic [7:0] STAT_PROTECTED = 8'h01;
  localparam logic [7:0] STAT_OPEN      = 8'h00;
endpackage

// File: rtl/fsg_group_bits.sv
module fsg_group_bits #(
  parameter int NUM_GROUPS = 32,
  parameter bit RESET_PROT = 1'b0,
  localparam int GW = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic                  clr_req,
  input  logic [GW-1:0]         idx,
  output logic [NUM_GROUPS-1:0] prot,
  output logic                  all_set
);
  assign all_set = &prot;

  // Per-group persistent protect flop; clearing needs every bit set first.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prot[g] <= RESET_PROT;
      else if (set_en && idx == GW'(g))
        prot[g] <= 1'b1;
      else if (clr_req && all_set && idx == GW'(g))
        prot[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fsg_protect_map.sv
module fsg_protect_map #(
  parameter int NUM_SECTORS = 128,
  parameter int GROUP_SIZE  = 4,
  parameter bit LOCK_TOP    = 1'b0,
  localparam int NG    = NUM_SECTORS / GROUP_SIZE,
  localparam int BOUND = LOCK_TOP ? NUM_SECTORS - 1 : 0
) (
  input  logic [NG-1:0]          grp_prot,
  input  logic                   lock_n,
  input  logic                   tmp_unlock,
  input  logic                   accel_mode,
  output logic [NUM_SECTORS-1:0] sect_prot
);
  logic groups_live;
  assign groups_live = !tmp_unlock && !accel_mode;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sect
    localparam int G = s / GROUP_SIZE;
    if (s == BOUND) begin : g_bound
      assign sect_prot[s] = (grp_prot[G] && groups_live) || !lock_n;
    end else begin : g_plain
      assign sect_prot[s] = grp_prot[G] && groups_live;
    end
  end
endmodule

// File: rtl/fsg_decide.sv
module fsg_decide
  import fsg_pkg::*;
#(
  parameter int NUM_SECTORS = 128,
  parameter int GROUP_SIZE  = 4,
  localparam int NG  = NUM_SECTORS / GROUP_SIZE,
  localparam int SW  = $clog2(NUM_SECTORS),
  localparam int GW  = $clog2(NG),
  localparam int GSH = $clog2(GROUP_SIZE)
) (
  input  logic [2:0]             op,
  input  logic [SW-1:0]          sector,
  input  logic [NUM_SECTORS-1:0] sect_prot,
  input  logic [NG-1:0]          grp_prot,
  input  logic                   all_set,
  output logic                   grant,
  output logic [7:0]             status,
  output logic [NUM_SECTORS-1:0] mask
);
  logic [GW-1:0] gidx;
  assign gidx = GW'(sector >> GSH);

  always_comb begin
    grant  = 1'b0;
    status = STAT_OPEN;
    mask   = '0;
    case (op_e'(op))
      OP_PROGRAM, OP_SECT_ERASE: grant = !sect_prot[sector];
      OP_CHIP_ERASE: begin
        mask  = ~sect_prot;
        grant = |mask;
      end
      OP_PROTECT:   grant = 1'b1;
      OP_UNPROTECT: grant = all_set;
      OP_VERIFY: begin
        grant  = 1'b1;
        status = grp_prot[gidx] ? STAT_PROTECTED : STAT_OPEN;
      end
      default: grant = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard
  import fsg_pkg::*;
#(
  parameter int NUM_SECTORS = 128,
  parameter int GROUP_SIZE  = 4,
  parameter bit LOCK_TOP    = 1'b0,
  parameter bit RESET_PROT  = 1'b0,
  localparam int NG  = NUM_SECTORS / GROUP_SIZE,
  localparam int SW  = $clog2(NUM_SECTORS),
  localparam int GW  = $clog2(NG),
  localparam int GSH = $clog2(GROUP_SIZE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock_n,
  input  logic                   tmp_unlock,
  input  logic                   accel_mode,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_op,
  input  logic [SW-1:0]          req_sector,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_grant,
  output logic [7:0]             rsp_status,
  output logic [NUM_SECTORS-1:0] rsp_erase_mask,
  output logic                   deny_pulse
);
  logic                   accept;
  logic [NG-1:0]          grp_prot;
  logic                   all_set;
  logic [NUM_SECTORS-1:0] sect_prot;
  logic                   grant_c;
  logic [7:0]             status_c;
  logic [NUM_SECTORS-1:0] mask_c;
  logic [GW-1:0]          gidx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign gidx      = GW'(req_sector >> GSH);

  fsg_group_bits #(.NUM_GROUPS(NG), .RESET_PROT(RESET_PROT)) i_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (accept && req_op == OP_PROTECT),
    .clr_req (accept && req_op == OP_UNPROTECT),
    .idx     (gidx),
    .prot    (grp_prot),
    .all_set (all_set)
  );

  fsg_protect_map #(
    .NUM_SECTORS(NUM_SECTORS), .GROUP_SIZE(GROUP_SIZE), .LOCK_TOP(LOCK_TOP)
  ) i_map (
    .grp_prot   (grp_prot),
    .lock_n     (lock_n),
    .tmp_unlock (tmp_unlock),
    .accel_mode (accel_mode),
    .sect_prot  (sect_prot)
  );

  fsg_decide #(.NUM_SECTORS(NUM_SECTORS), .GROUP_SIZE(GROUP_SIZE)) i_decide (
    .op        (req_op),
    .sector    (req_sector),
    .sect_prot (sect_prot),
    .grp_prot  (grp_prot),
    .all_set   (all_set),
    .grant     (grant_c),
    .status    (status_c),
    .mask      (mask_c)
  );

  // Single response slot; loads on accept, drains on consumer ready.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_grant      <= 1'b0;
      rsp_status     <= STAT_OPEN;
      rsp_erase_mask <= '0;
      deny_pulse     <= 1'b0;
    end else begin
      deny_pulse <= accept && !grant_c;
      if (accept) begin
        rsp_valid      <= 1'b1;
        rsp_grant      <= grant_c;
        rsp_status     <= status_c;
        rsp_erase_mask <= mask_c;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int NUM_SECTORS = 128,
  parameter int GROUP_SIZE  = 4,
  parameter bit LOCK_TOP    = 1'b0,
  localparam int NG  = NUM_SECTORS / GROUP_SIZE,
  localparam int SW  = $clog2(NUM_SECTORS),
  localparam int GW  = $clog2(NG),
  localparam int GSH = $clog2(GROUP_SIZE)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lock_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [2:0]             req_op,
  input logic [SW-1:0]          req_sector,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic                   rsp_grant,
  input logic [7:0]             rsp_status,
  input logic [NUM_SECTORS-1:0] rsp_erase_mask,
  input logic                   deny_pulse,
  input logic [NG-1:0]          grp_prot
);
  localparam logic [SW-1:0] BOUND_IDX = LOCK_TOP ? SW'(NUM_SECTORS - 1) : '0;
  logic          acc;
  logic [GW-1:0] gidx;
  assign acc  = req_valid && req_ready;
  assign gidx = GW'(req_sector >> GSH);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_grant)
      && $stable(rsp_status) && $stable(rsp_erase_mask));

  assert_deny_meaning_R11: assert property (@(posedge clk) disable iff (!rst_n)
    deny_pulse |-> rsp_valid && !rsp_grant);

  assert_deny_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> deny_pulse == !rsp_grant);

  assert_boundary_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lock_n && (req_op == 3'd0 || req_op == 3'd1) && req_sector == BOUND_IDX
      |=> !rsp_grant);

  assert_unprotect_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 3'd4 && !(&grp_prot) |=> !rsp_grant && $stable(grp_prot));

  assert_protect_sets_R13: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 3'd3 |=> rsp_grant && grp_prot[$past(gidx)]);

  assert_status_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status == 8'h00 || rsp_status == 8'h01);

  assert_mask_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (|rsp_erase_mask) |-> rsp_grant);
endmodule

bind flash_sector_guard fsg_checker #(
  .NUM_SECTORS(NUM_SECTORS), .GROUP_SIZE(GROUP_SIZE), .LOCK_TOP(LOCK_TOP)
) i_fsg_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .lock_n         (lock_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_op         (req_op),
  .req_sector     (req_sector),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_grant      (rsp_grant),
  .rsp_status     (rsp_status),
  .rsp_erase_mask (rsp_erase_mask),
  .deny_pulse     (deny_pulse),
  .grp_prot       (grp_prot)
);

// File: tb/test_flash_sector_guard.sv
module test_flash_sector_guard;
  localparam int NS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_n = 1'b1, tmp_unlock = 1'b0, accel_mode = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [2:0] req_op = 3'd0;
  logic [6:0] req_sector = 7'd0;
  logic req_ready, rsp_valid, rsp_grant, deny_pulse;
  logic [7:0] rsp_status;
  logic [NS-1:0] rsp_erase_mask;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_sector_guard i_flash_sector_guard (
    .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .tmp_unlock(tmp_unlock),
    .accel_mode(accel_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sector(req_sector), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_grant(rsp_grant), .rsp_status(rsp_status),
    .rsp_erase_mask(rsp_erase_mask), .deny_pulse(deny_pulse)
  );

  task automatic chk(string tag, logic [NS-1:0] act, logic [NS-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One request; returns after the response is visible on a falling edge.
  task automatic send(input logic [2:0] op, input logic [6:0] sec);
    @(negedge clk);
    req_op = op; req_sector = sec; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_grant(string tag, logic [2:0] op, logic [6:0] sec, logic g);
    send(op, sec);
    chk({tag, " grant"}, NS'(rsp_grant), NS'(g));
    chk({tag, " deny_pulse"}, NS'(deny_pulse), NS'(!g));
  endtask

  task automatic expect_verify(string tag, logic [6:0] sec, logic [7:0] st);
    send(3'd5, sec);
    chk({tag, " status"}, NS'(rsp_status), NS'(st));
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", NS'(rsp_valid), '0);
    chk("R1 deny_pulse", NS'(deny_pulse), '0);
    chk("R1 req_ready", NS'(req_ready), NS'(1));
    expect_verify("R1 group0", 7'd0, 8'h00);
    expect_verify("R1 group31", 7'd127, 8'h00);
  endtask

  task automatic t_basic;
    expect_grant("R2 program open", 3'd0, 7'd10, 1'b1);
    expect_grant("R13 protect g2", 3'd3, 7'd9, 1'b1);
    expect_grant("R2 program protected", 3'd0, 7'd10, 1'b0);
    @(negedge clk);
    chk("R11 pulse one cycle", NS'(deny_pulse), '0);
    expect_grant("R3 erase s8", 3'd1, 7'd8, 1'b0);
    expect_grant("R3 erase s12", 3'd1, 7'd12, 1'b1);
    expect_grant("R3 erase s7", 3'd1, 7'd7, 1'b1);
    expect_verify("R9 verify g2", 7'd11, 8'h01);
    send(3'd0, 7'd10);
    chk("R10 mask zero for program", rsp_erase_mask, '0);
    expect_grant("R2 code6", 3'd6, 7'd40, 1'b0);
    expect_grant("R2 code7", 3'd7, 7'd40, 1'b0);
  endtask

  task automatic t_lock;
    lock_n = 1'b0;
    expect_grant("R4 boundary locked", 3'd0, 7'd0, 1'b0);
    expect_grant("R4 neighbour free", 3'd0, 7'd1, 1'b1);
    expect_grant("R4 top sector free", 3'd1, 7'd127, 1'b1);
    lock_n = 1'b1;
    expect_grant("R5 boundary open", 3'd0, 7'd0, 1'b1);
    expect_grant("R13 protect g0", 3'd3, 7'd2, 1'b1);
    expect_grant("R5 boundary via bit", 3'd0, 7'd0, 1'b0);
  endtask

  task automatic t_tmp;
    expect_grant("R8 unprotect early", 3'd4, 7'd10, 1'b0);
    expect_verify("R8 bit kept", 7'd10, 8'h01);
    tmp_unlock = 1'b1; lock_n = 1'b0;
    expect_grant("R6 protected granted", 3'd0, 7'd10, 1'b1);
    expect_grant("R6 boundary still locked", 3'd0, 7'd0, 1'b0);
    expect_grant("R6 s1 granted", 3'd1, 7'd1, 1'b1);
    expect_verify("R9 verify under unlock", 7'd10, 8'h01);
    tmp_unlock = 1'b0; lock_n = 1'b1;
    expect_grant("R6 restored", 3'd0, 7'd10, 1'b0);
  endtask

  task automatic t_accel;
    accel_mode = 1'b1;
    expect_grant("R7 group open", 3'd0, 7'd10, 1'b1);
    expect_grant("R7 boundary open", 3'd0, 7'd0, 1'b1);
    expect_verify("R9 verify under accel", 7'd0, 8'h01);
    lock_n = 1'b0;
    expect_grant("R7 lock wins", 3'd1, 7'd0, 1'b0);
    accel_mode = 1'b0; lock_n = 1'b1;
    expect_grant("R7 after accel", 3'd0, 7'd10, 1'b0);
  endtask

  task automatic t_chip;
    logic [NS-1:0] exp;
    exp = '1;
    for (int i = 0; i < 4; i++) begin
      exp[i] = 1'b0;
      exp[8 + i] = 1'b0;
    end
    lock_n = 1'b0;
    send(3'd2, 7'd0);
    chk("R10 chip mask", rsp_erase_mask, exp);
    chk("R10 chip grant", NS'(rsp_grant), NS'(1));
    tmp_unlock = 1'b1;
    exp = '1; exp[0] = 1'b0;
    send(3'd2, 7'd77);
    chk("R10 chip mask unlocked", rsp_erase_mask, exp);
    tmp_unlock = 1'b0; lock_n = 1'b1;
  endtask

  task automatic t_unprotect;
    for (int g = 0; g < 32; g++) send(3'd3, 7'(g * 4));
    send(3'd2, 7'd0);
    chk("R10 all protected mask", rsp_erase_mask, '0);
    chk("R10 all protected grant", NS'(rsp_grant), '0);
    chk("R11 chip deny pulse", NS'(deny_pulse), NS'(1));
    expect_grant("R8 unprotect g5", 3'd4, 7'd21, 1'b1);
    expect_verify("R8 g5 cleared", 7'd20, 8'h00);
    expect_verify("R8 g6 kept", 7'd24, 8'h01);
    expect_verify("R8 g4 kept", 7'd19, 8'h01);
    expect_grant("R8 second unprotect", 3'd4, 7'd25, 1'b0);
    expect_verify("R8 g6 still set", 7'd26, 8'h01);
    expect_grant("R2 program reopened", 3'd0, 7'd22, 1'b1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_op = 3'd5; req_sector = 7'd24; req_valid = 1'b1;
    @(negedge clk);
    chk("R12 first response", NS'(rsp_status), NS'(8'h01));
    chk("R12 ready low", NS'(req_ready), '0);
    req_op = 3'd0; req_sector = 7'd21;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 held valid", NS'(rsp_valid), NS'(1));
      chk("R12 held status", NS'(rsp_status), NS'(8'h01));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 next response status", NS'(rsp_status), '0);
    chk("R12 next response grant", NS'(rsp_grant), NS'(1));
    @(negedge clk);
    chk("R12 drained", NS'(rsp_valid), '0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lock();
    t_tmp();
    t_accel();
    t_chip();
    t_unprotect();
    t_backpressure();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule